// File: doc/BRIEF.md
# Conditional Branch and Skip Resolver

This block decides where a small processor goes next after a conditional control-flow instruction, and how many cycles that instruction occupies. Each request gives the current program counter, a signed 7-bit relative offset, the eight status flags, an instruction class, a flag index with a polarity, an equality result from a compare, a tested operand bit, and a hint saying whether the instruction after this one takes two words. One clock later the block returns the next program counter, the cycle cost and a taken indication.

Three classes are resolved. A flag branch jumps relative to the PC when the chosen status flag matches the polarity. A compare skip jumps over the next instruction when the equality input is high. A bit-test skip jumps over the next instruction when the tested bit matches the polarity. The sign flag is never read from its stored bit: it is rebuilt as negative XOR overflow, so signed greater-or-equal and less-than follow the arithmetic flags directly. Decoding and the register file sit outside this block.

Top module: `branch_skip_resolver`

## Requirements
- R1: A taken flag branch yields next PC = PC + sign-extended offset + 1, where the offset is 7-bit two's complement and the sum wraps modulo 2^PC_W.
- R2: A flag branch costs 2 cycles when taken; when not taken it costs 1 cycle and the next PC is PC + 1.
- R3: Class code 2'b01 (compare skip) skips when eq_i is 1; the next PC is then PC + 2 if two_word_i is 0 and PC + 3 if two_word_i is 1, wrapping modulo 2^PC_W.
- R4: Class code 2'b10 (bit-test skip) skips when test_bit_i equals polarity_i, with the same distances as R3.
- R5: A skip-class instruction costs 1 cycle with no skip (next PC = PC + 1), 2 cycles when skipping a one-word instruction and 3 when skipping a two-word instruction.
- R6: Class code 2'b00 (flag branch) is taken when status bit flag_idx_i equals polarity_i (1 = branch when set); status bits from 7 down to 0 are I, T, H, S, V, N, Z, C, so unsigned same-or-higher is index 0 with polarity 0 and unsigned lower is index 0 with polarity 1.
- R7: Selecting index 4 (sign) evaluates bit 2 (N) XOR bit 3 (V); the stored value of bit 4 has no effect. Polarity 0 gives signed greater-or-equal, polarity 1 gives signed less-than.
- R8: Class code 2'b11 is reserved: next PC = PC + 1, 1 cycle, taken_o low, whatever the flags and inputs.
- R9: Results appear on the clock edge after the request is sampled with valid_i high; valid_o is high for exactly one cycle per request; reset sets valid_o, taken_o, next_pc_o and cycles_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| cls_i | input | 2 | Instruction class: 00 flag branch, 01 compare skip, 10 bit-test skip, 11 reserved |
| pc_i | input | PC_W | Current program counter |
| offset_i | input | OFS_W | Signed relative branch offset |
| sreg_i | input | 8 | Status flags I,T,H,S,V,N,Z,C from bit 7 to 0 |
| flag_idx_i | input | 3 | Status bit index for flag branches |
| polarity_i | input | 1 | 1 = act when bit is set, 0 = act when clear |
| eq_i | input | 1 | Compare equality result |
| test_bit_i | input | 1 | Value of the tested operand bit |
| two_word_i | input | 1 | Following instruction is two words long |
| valid_o | output | 1 | Result strobe |
| next_pc_o | output | PC_W | Resolved next program counter |
| cycles_o | output | 2 | Cycle cost of the instruction |
| taken_o | output | 1 | Branch taken or skip performed |

## Verification
Every result is due exactly one clock edge after its request is sampled, since the block has a single output register stage and nothing else in the path. The driver applies a request on a falling edge and records the expected PC, cycle count and taken value; the monitor compares on the following falling edge, when the output register has loaded and is stable, and flags any valid_o pulse that arrives without a matching expectation. Idle cycles between bursts confirm that valid_o falls back to 0.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    CLS_FLAG_BR  = 2'b00,
    CLS_CMP_SKIP = 2'b01,
    CLS_BIT_SKIP = 2'b10,
    CLS_RSVD     = 2'b11
  } ctl_class_e;

  localparam int SR_BITS = 8;
  localparam int IDX_W   = $clog2(SR_BITS);
  localparam int CYC_W   = 2;

  // status bit positions
  localparam int SR_C = 0;
  localparam int SR_Z = 1;
  localparam int SR_N = 2;
  localparam int SR_V = 3;
  localparam int SR_S = 4;
  localparam int SR_H = 5;
  localparam int SR_T = 6;
  localparam int SR_I = 7;

endpackage

// File: rtl/bsr_cond.sv
module bsr_cond
  import bsr_pkg::*;
(
  input  ctl_class_e         cls_i,
  input  logic [SR_BITS-1:0] sreg_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               pol_i,
  input  logic               eq_i,
  input  logic               test_bit_i,
  output logic               hit_o,
  output logic               skip_cls_o,
  output logic               branch_cls_o
);

  logic [SR_BITS-1:0] eff_flags;

  // Sign flag is rebuilt from N and V; every other bit passes through.
  for (genvar g = 0; g < SR_BITS; g++) begin : g_flag
    if (g == SR_S) begin : g_sign
      assign eff_flags[g] = sreg_i[SR_N] ^ sreg_i[SR_V];
    end else begin : g_pass
      assign eff_flags[g] = sreg_i[g];
    end
  end

  always_comb begin
    hit_o        = 1'b0;
    skip_cls_o   = 1'b0;
    branch_cls_o = 1'b0;
    unique case (cls_i)
      CLS_FLAG_BR: begin
        branch_cls_o = 1'b1;
        hit_o        = (eff_flags[idx_i] == pol_i);
      end
      CLS_CMP_SKIP: begin
        skip_cls_o = 1'b1;
        hit_o      = eq_i;
      end
      CLS_BIT_SKIP: begin
        skip_cls_o = 1'b1;
        hit_o      = (test_bit_i == pol_i);
      end
      default: begin
        hit_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bsr_target.sv
module bsr_target
  import bsr_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 7
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             hit_i,
  input  logic             skip_cls_i,
  input  logic             branch_cls_i,
  input  logic             two_word_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic [CYC_W-1:0] cycles_o,
  output logic             taken_o
);

  logic [PC_W-1:0] ofs_ext;

  if (PC_W > OFS_W) begin : g_sext
    assign ofs_ext = {{(PC_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
  end else begin : g_trunc
    assign ofs_ext = ofs_i[PC_W-1:0];
  end

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] br_pc;
  logic [PC_W-1:0] skip_pc;

  assign seq_pc  = pc_i + PC_W'(1);
  assign br_pc   = pc_i + ofs_ext + PC_W'(1);
  assign skip_pc = pc_i + (two_word_i ? PC_W'(3) : PC_W'(2));

  always_comb begin
    next_pc_o = seq_pc;
    cycles_o  = CYC_W'(1);
    taken_o   = 1'b0;
    if (hit_i && branch_cls_i) begin
      next_pc_o = br_pc;
      cycles_o  = CYC_W'(2);
      taken_o   = 1'b1;
    end else if (hit_i && skip_cls_i) begin
      next_pc_o = skip_pc;
      cycles_o  = two_word_i ? CYC_W'(3) : CYC_W'(2);
      taken_o   = 1'b1;
    end
  end

endmodule

// File: rtl/branch_skip_resolver.sv
module branch_skip_resolver
  import bsr_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [1:0]       cls_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [7:0]       sreg_i,
  input  logic [2:0]       flag_idx_i,
  input  logic             polarity_i,
  input  logic             eq_i,
  input  logic             test_bit_i,
  input  logic             two_word_i,
  output logic             valid_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic [1:0]       cycles_o,
  output logic             taken_o
);

  ctl_class_e      cls;
  logic            hit;
  logic            skip_cls;
  logic            branch_cls;
  logic [PC_W-1:0] nxt_pc;
  logic [CYC_W-1:0] nxt_cyc;
  logic            nxt_taken;

  assign cls = ctl_class_e'(cls_i);

  bsr_cond u_cond (
    .cls_i        (cls),
    .sreg_i       (sreg_i),
    .idx_i        (flag_idx_i),
    .pol_i        (polarity_i),
    .eq_i         (eq_i),
    .test_bit_i   (test_bit_i),
    .hit_o        (hit),
    .skip_cls_o   (skip_cls),
    .branch_cls_o (branch_cls)
  );

  bsr_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_target (
    .pc_i         (pc_i),
    .ofs_i        (offset_i),
    .hit_i        (hit),
    .skip_cls_i   (skip_cls),
    .branch_cls_i (branch_cls),
    .two_word_i   (two_word_i),
    .next_pc_o    (nxt_pc),
    .cycles_o     (nxt_cyc),
    .taken_o      (nxt_taken)
  );

  // request PC and class kept beside the result for the checks below
  logic [PC_W-1:0] pc_q;
  ctl_class_e      cls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      next_pc_o <= '0;
      cycles_o  <= '0;
      taken_o   <= 1'b0;
      pc_q      <= '0;
      cls_q     <= CLS_FLAG_BR;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        next_pc_o <= nxt_pc;
        cycles_o  <= nxt_cyc;
        taken_o   <= nxt_taken;
        pc_q      <= pc_i;
        cls_q     <= cls;
      end
    end
  end

  // R9: one result strobe per sampled request
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  // R2: branch cost tracks the taken decision
  p_branch_cycles_r2: assert property (@(posedge clk) disable iff (rst)
    (valid_o && cls_q == CLS_FLAG_BR) |-> (cycles_o == (taken_o ? 2'd2 : 2'd1)));

  // R5: a performed skip moves the PC by exactly its cycle cost
  p_skip_dist_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && taken_o && cls_q != CLS_FLAG_BR) |->
      (next_pc_o == pc_q + PC_W'(cycles_o)));

  // R2/R5: anything not taken steps by one in a single cycle
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !taken_o) |-> (next_pc_o == pc_q + PC_W'(1) && cycles_o == 2'd1));

  // R8: the reserved class never redirects
  p_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && cls_q == CLS_RSVD) |-> !taken_o);

endmodule

// File: tb/branch_skip_resolver_bench.sv
module branch_skip_resolver_bench;

  localparam int PC_W  = 16;
  localparam int OFS_W = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             valid_i = 1'b0;
  logic [1:0]       cls_i = '0;
  logic [PC_W-1:0]  pc_i = '0;
  logic [OFS_W-1:0] offset_i = '0;
  logic [7:0]       sreg_i = '0;
  logic [2:0]       flag_idx_i = '0;
  logic             polarity_i = 1'b0;
  logic             eq_i = 1'b0;
  logic             test_bit_i = 1'b0;
  logic             two_word_i = 1'b0;
  logic             valid_o;
  logic [PC_W-1:0]  next_pc_o;
  logic [1:0]       cycles_o;
  logic             taken_o;

  always #4 clk = ~clk;

  branch_skip_resolver #(.PC_W(PC_W), .OFS_W(OFS_W)) u_branch_skip_resolver (
    .clk(clk), .rst(rst), .valid_i(valid_i), .cls_i(cls_i), .pc_i(pc_i),
    .offset_i(offset_i), .sreg_i(sreg_i), .flag_idx_i(flag_idx_i),
    .polarity_i(polarity_i), .eq_i(eq_i), .test_bit_i(test_bit_i),
    .two_word_i(two_word_i), .valid_o(valid_o), .next_pc_o(next_pc_o),
    .cycles_o(cycles_o), .taken_o(taken_o)
  );

  typedef struct {
    logic [PC_W-1:0] pc;
    logic [1:0]      cyc;
    logic            tkn;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  task automatic req(input logic [1:0] c, input logic [PC_W-1:0] pc,
                     input logic [OFS_W-1:0] ofs, input logic [7:0] sr,
                     input logic [2:0] idx, input logic pol, input logic eq,
                     input logic tb, input logic tw,
                     input logic [PC_W-1:0] e_pc, input logic [1:0] e_cyc,
                     input logic e_tkn, input string tag);
    exp_t e;
    @(negedge clk);
    valid_i = 1'b1; cls_i = c; pc_i = pc; offset_i = ofs; sreg_i = sr;
    flag_idx_i = idx; polarity_i = pol; eq_i = eq; test_bit_i = tb;
    two_word_i = tw;
    e.pc = e_pc; e.cyc = e_cyc; e.tkn = e_tkn; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // monitor: results are due one edge after the request, sampled at negedge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (valid_o) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected valid_o: actual 1 expected 0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (next_pc_o !== e.pc || cycles_o !== e.cyc || taken_o !== e.tkn) begin
            errors++;
            $display("FAIL %s: actual pc=%h cyc=%0d tkn=%0b expected pc=%h cyc=%0d tkn=%0b",
                     e.tag, next_pc_o, cycles_o, taken_o, e.pc, e.cyc, e.tkn);
          end
        end
      end else if (exp_q.size() != 0 && !valid_i) begin
        checks++;
        errors++;
        $display("FAIL R9 missing valid_o: actual 0 expected 1 (%s)", exp_q[0].tag);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    checks++;
    if (valid_o !== 1'b0 || next_pc_o !== '0 || cycles_o !== 2'd0 || taken_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: actual v=%b pc=%h cyc=%0d t=%b expected all zero",
               valid_o, next_pc_o, cycles_o, taken_o);
    end
    rst = 1'b0;
    idle(2);

    // R1/R6: Z set (idx 1), branch when set
    req(2'b00, 16'd100, 7'd5,    8'h02, 3'd1, 1'b1, 0, 0, 0, 16'd106, 2'd2, 1'b1, "R1 forward");
    req(2'b00, 16'd100, 7'h7F,   8'h02, 3'd1, 1'b1, 0, 0, 1, 16'd100, 2'd2, 1'b1, "R1 offset -1");
    req(2'b00, 16'd10,  7'h40,   8'h02, 3'd1, 1'b1, 0, 0, 0, 16'hFFCB, 2'd2, 1'b1, "R1 wrap low");
    req(2'b00, 16'hFFFF, 7'd3,   8'h02, 3'd1, 1'b1, 0, 0, 0, 16'h0003, 2'd2, 1'b1, "R1 wrap high");
    // R2 not taken
    req(2'b00, 16'd200, 7'd20,   8'h00, 3'd1, 1'b1, 1, 1, 1, 16'd201, 2'd1, 1'b0, "R2 not taken");
    // R6 carry: same-or-higher and lower
    req(2'b00, 16'd300, 7'd8,    8'hFE, 3'd0, 1'b0, 0, 0, 0, 16'd309, 2'd2, 1'b1, "R6 same-or-higher");
    req(2'b00, 16'd300, 7'd8,    8'hFE, 3'd0, 1'b1, 0, 0, 0, 16'd301, 2'd1, 1'b0, "R6 lower not taken");
    req(2'b00, 16'd300, 7'd8,    8'h01, 3'd0, 1'b1, 0, 0, 0, 16'd309, 2'd2, 1'b1, "R6 lower taken");
    // R6 high bits I and T
    req(2'b00, 16'd400, 7'h7C,   8'h80, 3'd7, 1'b1, 0, 0, 0, 16'd397, 2'd2, 1'b1, "R6 bit7 I");
    req(2'b00, 16'd400, 7'd2,    8'hBF, 3'd6, 1'b0, 0, 0, 0, 16'd403, 2'd2, 1'b1, "R6 bit6 T clear");
    idle(2);
    // R7 signed from N xor V; stored S disagrees
    req(2'b00, 16'd500, 7'd10,   8'h04, 3'd4, 1'b0, 0, 0, 0, 16'd501, 2'd1, 1'b0, "R7 GE with N^V=1");
    req(2'b00, 16'd500, 7'd10,   8'h04, 3'd4, 1'b1, 0, 0, 0, 16'd511, 2'd2, 1'b1, "R7 LT with S=0");
    req(2'b00, 16'd500, 7'd10,   8'h1C, 3'd4, 1'b0, 0, 0, 0, 16'd511, 2'd2, 1'b1, "R7 GE with N=V=S=1");
    // R3/R5 compare skip
    req(2'b01, 16'd600, 7'd50,   8'h00, 3'd0, 1'b0, 1, 0, 0, 16'd602, 2'd2, 1'b1, "R3 skip one word");
    req(2'b01, 16'd600, 7'd50,   8'h00, 3'd0, 1'b0, 1, 0, 1, 16'd603, 2'd3, 1'b1, "R5 skip two words");
    req(2'b01, 16'd600, 7'd50,   8'hFF, 3'd1, 1'b1, 0, 1, 1, 16'd601, 2'd1, 1'b0, "R5 no skip");
    req(2'b01, 16'hFFFE, 7'd0,   8'h00, 3'd0, 1'b0, 1, 0, 1, 16'h0001, 2'd3, 1'b1, "R3 skip wrap");
    // R4 bit test skip
    req(2'b10, 16'd700, 7'd9,    8'h00, 3'd0, 1'b0, 0, 0, 0, 16'd702, 2'd2, 1'b1, "R4 bit clear skip");
    req(2'b10, 16'd700, 7'd9,    8'h00, 3'd0, 1'b0, 1, 1, 1, 16'd701, 2'd1, 1'b0, "R4 bit set no skip");
    req(2'b10, 16'd700, 7'd9,    8'h00, 3'd0, 1'b1, 0, 1, 1, 16'd703, 2'd3, 1'b1, "R4 bit set skip");
    // R8 reserved class
    req(2'b11, 16'd800, 7'd30,   8'hFF, 3'd1, 1'b1, 1, 1, 1, 16'd801, 2'd1, 1'b0, "R8 reserved");
    idle(4);
    checks++;
    if (exp_q.size() != 0 || valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 drain: actual pending=%0d valid=%b expected 0 0", exp_q.size(), valid_o);
    end
    finish_run();
  end

endmodule